// File: doc/BRIEF.md
# Interrupt Arbitration and Vectoring Unit

This block sits next to a small 8-bit processor core and decides, at every instruction boundary, whether the core enters an interrupt sequence or fetches its next instruction. Four level-sensitive hardware request lines feed it: an external pin source, a timer, a serial communications port and an SPI port. Each line has its own enable bit. The block owns the global interrupt mask bit. A software-interrupt instruction counts as an unmaskable interrupt source of its own.

A hardware request never cuts an instruction short. It waits until the core reports an instruction as complete. The core then receives either a one-clock take pulse with a vector address, or a one-clock fetch-next pulse. Every grant sets the mask. The core later restores the mask through a load port, which it uses for the return-from-interrupt path or for explicit mask writes. The vector stays frozen until the core acknowledges it.

When the software-interrupt opcode is fetched, the enabled requests pending at that moment are latched into a snapshot, provided the mask is clear. At later boundaries only those snapshot members are served ahead of the software interrupt. Requests raised after the fetch wait until the software interrupt has been taken.

Top module: `irqv_top`

## Requirements
- R1: A grant (`take`) or a `fetch_next` pulse appears only in the cycle after a cycle with `insn_done` high. Pending requests alone never produce a grant.
- R2: A hardware source is granted only when the mask is clear and that source's enable bit is set. A boundary with nothing to grant produces a single `fetch_next` pulse.
- R3: Hardware priority follows the index of `hw_req`: bit 0 (external) beats bit 1 (timer), which beats bit 2 (serial comms), which beats bit 3 (SPI).
- R4: `vec_addr` gives the address of the high byte of the vector pair, and the low byte sits at the next address. The values are: external 0x3FFA, timer 0x3FF8, serial comms 0x3FF6, SPI 0x3FF4, software interrupt 0x3FFC.
- R5: Every grant sets `imask`, and `set_mask` pulses together with `take`. Outside a grant, `mask_load` copies `mask_val` into `imask`.
- R6: A pending software interrupt is granted at the next boundary even when `imask` is set.
- R7: While a software interrupt is pending, only snapshot members that are still requesting and enabled are granted before it, and only while the mask is clear. Requests that are not in the snapshot wait until after the software interrupt.
- R8: `take` lasts exactly one clock per grant.
- R9: After a grant, `vec_addr` holds steady and no further grant or `fetch_next` occurs until `vec_ack` is seen.
- R10: After reset: `take`=0, `fetch_next`=0, `set_mask`=0, `imask`=1, `snap_pend`=0 and `vec_addr`=0x3FFE.
- R11: `snap_pend` loads the enabled pending requests on a `swi_fetch` cycle, or 0 if the mask is set at that point. The bit of a granted snapshot member clears, and the whole snapshot clears when the software interrupt is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 4 | Level request lines, bit 0 external, 1 timer, 2 serial comms, 3 SPI |
| hw_en | input | 4 | Per-source enable bits, same order |
| insn_done | input | 1 | Instruction-complete strobe |
| swi_fetch | input | 1 | Software-interrupt opcode fetched |
| mask_load | input | 1 | Load the mask from mask_val (return-from-interrupt restore) |
| mask_val | input | 1 | Mask value to load |
| vec_ack | input | 1 | Core has consumed the vector |
| take | output | 1 | One-clock grant pulse |
| fetch_next | output | 1 | One-clock pulse: boundary with no grant |
| set_mask | output | 1 | Mask-set command, coincident with take |
| vec_addr | output | 16 | High-byte address of the granted vector pair |
| imask | output | 1 | Current global mask bit |
| snap_pend | output | 4 | Snapshot of requests pending at the software-interrupt fetch |

## Verification
The bench builds the block with its default four hardware sources and a vector top of 0x3FFE. With only four sources and one mask bit, the plain boundary behaviour can be swept over every request pattern, every enable pattern and both mask states: 512 combinations, each checked against a priority and vector computed in the bench. Directed sequences then cover the software-interrupt ordering: a snapshot taken with the mask set, a late external request overtaken by snapshot members, the grant-and-clear behaviour of the snapshot, and an unacknowledged vector blocking a second boundary.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    GR_NONE = 2'd0,
    GR_HW   = 2'd1,
    GR_SWI  = 2'd2
  } grant_kind_e;

  // index of lowest set bit (lowest index = highest priority); 0 when empty
  function automatic int unsigned lowest_set(input logic [7:0] v);
    int unsigned r;
    r = 0;
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // hardware vectors descend in 2-byte steps below the software vector
  function automatic logic [15:0] hw_vector(input logic [15:0] top,
                                            input int unsigned idx);
    return top - 16'd4 - 16'(2 * idx);
  endfunction

  function automatic logic [15:0] swi_vector(input logic [15:0] top);
    return top - 16'd2;
  endfunction

endpackage

// File: rtl/irqv_mask.sv
module irqv_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic set_cmd,
  input  logic load,
  input  logic load_val,
  output logic imask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       imask <= 1'b1;
    else if (set_cmd) imask <= 1'b1;
    else if (load)    imask <= load_val;
  end
endmodule

// File: rtl/irqv_snapshot.sv
module irqv_snapshot
  import irqv_pkg::*;
#(
  parameter int NUM_HW = 4,
  localparam int IDX_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swi_fetch,
  input  logic              imask,
  input  logic [NUM_HW-1:0] live,
  input  logic              boundary,
  input  grant_kind_e       kind,
  input  logic [IDX_W-1:0]  idx,
  output logic [NUM_HW-1:0] snap,
  output logic              swi_pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap     <= '0;
      swi_pend <= 1'b0;
    end else begin
      if (boundary && kind == GR_SWI) begin
        swi_pend <= 1'b0;
        snap     <= '0;
      end else if (boundary && kind == GR_HW && swi_pend) begin
        snap[idx] <= 1'b0;
      end
      if (swi_fetch) begin
        swi_pend <= 1'b1;
        snap     <= imask ? '0 : live;
      end
    end
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int          NUM_HW  = 4,
  parameter logic [15:0] VEC_TOP = 16'h3FFE,
  localparam int IDX_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic [NUM_HW-1:0] live,
  input  logic [NUM_HW-1:0] snap,
  input  logic              swi_pend,
  input  logic              imask,
  output grant_kind_e       kind,
  output logic [IDX_W-1:0]  idx,
  output logic [15:0]       vec
);
  logic [NUM_HW-1:0] pool;
  logic [7:0]        pool8;

  always_comb begin
    pool = swi_pend ? (snap & live) : live;
    if (imask) pool = '0;
    pool8 = '0;
    pool8[NUM_HW-1:0] = pool;
    idx = IDX_W'(lowest_set(pool8));
    if (|pool) begin
      kind = GR_HW;
      vec  = hw_vector(VEC_TOP, lowest_set(pool8));
    end else if (swi_pend) begin
      kind = GR_SWI;
      vec  = swi_vector(VEC_TOP);
    end else begin
      kind = GR_NONE;
      vec  = VEC_TOP;
    end
  end
endmodule

// File: rtl/irqv_vector_hold.sv
module irqv_vector_hold
  import irqv_pkg::*;
#(
  parameter logic [15:0] VEC_TOP = 16'h3FFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary,
  input  grant_kind_e kind,
  input  logic [15:0] vec,
  input  logic        vec_ack,
  output logic        take,
  output logic        set_mask,
  output logic        fetch_next,
  output logic [15:0] vec_addr,
  output logic        busy
);
  logic grant;
  assign grant = boundary && (kind != GR_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take       <= 1'b0;
      set_mask   <= 1'b0;
      fetch_next <= 1'b0;
      vec_addr   <= VEC_TOP;
      busy       <= 1'b0;
    end else begin
      take       <= grant;
      set_mask   <= grant;
      fetch_next <= boundary && (kind == GR_NONE);
      if (grant) begin
        vec_addr <= vec;
        busy     <= 1'b1;
      end else if (vec_ack) begin
        busy     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
#(
  parameter int          NUM_HW  = 4,
  parameter logic [15:0] VEC_TOP = 16'h3FFE,
  localparam int IDX_W = (NUM_HW > 1) ? $clog2(NUM_HW) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_HW-1:0] hw_req,
  input  logic [NUM_HW-1:0] hw_en,
  input  logic              insn_done,
  input  logic              swi_fetch,
  input  logic              mask_load,
  input  logic              mask_val,
  input  logic              vec_ack,
  output logic              take,
  output logic              fetch_next,
  output logic              set_mask,
  output logic [15:0]       vec_addr,
  output logic              imask,
  output logic [NUM_HW-1:0] snap_pend
);
  // named internal events, visible to the bound checker
  logic [NUM_HW-1:0] live_w;
  logic              busy_w;
  logic              boundary_w;
  logic              swi_pend_w;
  logic              grant_w;
  grant_kind_e       kind_w;
  logic [IDX_W-1:0]  idx_w;
  logic [15:0]       vec_w;

  assign live_w     = hw_req & hw_en;
  assign boundary_w = insn_done & ~busy_w;
  assign grant_w    = boundary_w && (kind_w != GR_NONE);

  irqv_arbiter #(.NUM_HW(NUM_HW), .VEC_TOP(VEC_TOP)) arb_i (
    .live(live_w), .snap(snap_pend), .swi_pend(swi_pend_w), .imask(imask),
    .kind(kind_w), .idx(idx_w), .vec(vec_w)
  );

  irqv_snapshot #(.NUM_HW(NUM_HW)) snap_i (
    .clk(clk), .rst_n(rst_n), .swi_fetch(swi_fetch), .imask(imask),
    .live(live_w), .boundary(boundary_w), .kind(kind_w), .idx(idx_w),
    .snap(snap_pend), .swi_pend(swi_pend_w)
  );

  irqv_mask mask_i (
    .clk(clk), .rst_n(rst_n), .set_cmd(grant_w), .load(mask_load),
    .load_val(mask_val), .imask(imask)
  );

  irqv_vector_hold #(.VEC_TOP(VEC_TOP)) hold_i (
    .clk(clk), .rst_n(rst_n), .boundary(boundary_w), .kind(kind_w),
    .vec(vec_w), .vec_ack(vec_ack), .take(take), .set_mask(set_mask),
    .fetch_next(fetch_next), .vec_addr(vec_addr), .busy(busy_w)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int          NUM_HW  = 4,
  parameter logic [15:0] VEC_TOP = 16'h3FFE
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_HW-1:0] hw_req,
  input logic [NUM_HW-1:0] hw_en,
  input logic              insn_done,
  input logic              vec_ack,
  input logic              take,
  input logic [15:0]       vec_addr,
  input logic              imask,
  input logic [NUM_HW-1:0] snap_pend,
  input logic              busy_w,
  input logic              swi_pend_w
);
  localparam logic [15:0] SWI_V = VEC_TOP - 16'd2;
  localparam logic [15:0] EXT_V = VEC_TOP - 16'd4;

  assert_take_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  assert_grant_sets_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> imask);

  assert_vec_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !vec_ack) |=> $stable(vec_addr));

  assert_only_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(insn_done));

  assert_hw_needs_clear_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_addr != SWI_V) |-> $past(!imask));

  assert_ext_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !busy_w && !imask && !swi_pend_w && hw_req[0] && hw_en[0])
      |=> (take && vec_addr == EXT_V));

  assert_swi_unmaskable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !busy_w && swi_pend_w &&
     (imask || (snap_pend & hw_req & hw_en) == '0))
      |=> (take && vec_addr == SWI_V));
endmodule

bind irqv_top irqv_checker #(.NUM_HW(NUM_HW), .VEC_TOP(VEC_TOP)) chk_i (
  .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_en(hw_en),
  .insn_done(insn_done), .vec_ack(vec_ack), .take(take),
  .vec_addr(vec_addr), .imask(imask), .snap_pend(snap_pend),
  .busy_w(busy_w), .swi_pend_w(swi_pend_w)
);

// File: tb/irqv_top_tb_top.sv
module irqv_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  hw_req = '0, hw_en = '0;
  logic        insn_done = 0, swi_fetch = 0, mask_load = 0, mask_val = 0, vec_ack = 0;
  logic        take, fetch_next, set_mask, imask;
  logic [15:0] vec_addr;
  logic [3:0]  snap_pend;
  int          n_chk = 0, n_fail = 0;
  logic        done = 0;

  always #2ns clk = ~clk;

  irqv_top dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_en(hw_en),
    .insn_done(insn_done), .swi_fetch(swi_fetch), .mask_load(mask_load),
    .mask_val(mask_val), .vec_ack(vec_ack), .take(take),
    .fetch_next(fetch_next), .set_mask(set_mask), .vec_addr(vec_addr),
    .imask(imask), .snap_pend(snap_pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side vector arithmetic: SPI lowest, each step up adds two
  function automatic logic [15:0] exp_hw_vec(input int k);
    return 16'h3FF4 + 16'(2 * (3 - k));
  endfunction

  task automatic boundary();
    insn_done = 1; @(negedge clk); insn_done = 0;
  endtask
  task automatic ack();
    vec_ack = 1; @(negedge clk); vec_ack = 0;
  endtask
  task automatic load_mask(input logic v);
    mask_load = 1; mask_val = v; @(negedge clk); mask_load = 0;
  endtask
  task automatic fetch_swi();
    swi_fetch = 1; @(negedge clk); swi_fetch = 0;
  endtask

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 take", 32'(take), 0);
    chk("R10 fetch_next", 32'(fetch_next), 0);
    chk("R10 set_mask", 32'(set_mask), 0);
    chk("R10 imask", 32'(imask), 1);
    chk("R10 snap", 32'(snap_pend), 0);
    chk("R10 vec", 32'(vec_addr), 32'h3FFE);

    // R2 R3 R4 R5: full sweep of requests, enables and mask
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 16; r++) begin
        for (int e = 0; e < 16; e++) begin
          logic [3:0] lv;
          int low;
          load_mask(m[0]);
          hw_req = 4'(r); hw_en = 4'(e);
          lv = 4'(r & e);
          low = -1;
          for (int k = 3; k >= 0; k--) if (lv[k]) low = k;
          boundary();
          if (m == 0 && low >= 0) begin
            chk("R2 take", 32'(take), 1);
            chk("R4 R3 vector", 32'(vec_addr), 32'(exp_hw_vec(low)));
            chk("R5 set_mask", 32'(set_mask), 1);
            chk("R5 imask", 32'(imask), 1);
            ack();
          end else begin
            chk("R2 no take", 32'(take), 0);
            chk("R2 fetch_next", 32'(fetch_next), 1);
          end
        end
      end
    end

    // R1: pending request without a boundary is never granted
    hw_req = 4'b0001; hw_en = 4'b1111; load_mask(0);
    repeat (5) @(negedge clk);
    chk("R1 no take without boundary", 32'(take), 0);
    boundary();
    chk("R1 take after boundary", 32'(take), 1);
    @(negedge clk);
    chk("R8 take one clock", 32'(take), 0);

    // R9: unacknowledged vector blocks the next boundary
    hw_req = 4'b0100; load_mask(0);
    boundary();
    chk("R9 no take while busy", 32'(take), 0);
    chk("R9 no fetch while busy", 32'(fetch_next), 0);
    chk("R9 vec held", 32'(vec_addr), 32'h3FFA);
    ack();
    boundary();
    chk("R9 grant after ack", 32'(vec_addr), 32'h3FF6);
    ack();

    // R6 R11: software interrupt fetched with the mask set
    hw_req = 4'b1111; load_mask(1);
    fetch_swi();
    chk("R11 snap empty when masked", 32'(snap_pend), 0);
    boundary();
    chk("R6 take", 32'(take), 1);
    chk("R6 swi vector", 32'(vec_addr), 32'h3FFC);
    ack();

    // R7 R11: ordering around the fetch
    hw_req = 4'b1010; load_mask(0);
    fetch_swi();
    chk("R11 snap captured", 32'(snap_pend), 32'hA);
    hw_req = 4'b1011;              // external raised after the fetch
    boundary();
    chk("R7 snapshot timer first", 32'(vec_addr), 32'h3FF8);
    chk("R11 granted bit cleared", 32'(snap_pend), 32'h8);
    ack(); hw_req = 4'b1001; load_mask(0);
    boundary();
    chk("R7 snapshot spi next", 32'(vec_addr), 32'h3FF4);
    chk("R11 snap empty", 32'(snap_pend), 0);
    ack(); hw_req = 4'b0001; load_mask(0);
    boundary();
    chk("R7 swi before late ext", 32'(vec_addr), 32'h3FFC);
    ack(); load_mask(0);
    boundary();
    chk("R7 late ext after swi", 32'(vec_addr), 32'h3FFA);
    ack();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule